// File: doc/BRIEF.md
# Sticky Thermal Status Log Register

This block holds a package-level thermal status word for a serial host interface to read. Three live condition inputs feed it: thermal control circuit active, bidirectional hot signal asserted, and critical temperature reached. Each condition appears in the word twice. One bit is a live status bit that follows the synchronized input. The other is a sticky log bit that records any rising edge of that status.

A host reads the word with a one-cycle request pulse that carries a 32-bit clear mask, which is active low. One cycle later the block returns a valid pulse, the word as it stood before the read, and a completion code. After a successful read, every log bit whose mask bit is 0 is cleared. A mask that places a 0 where no log bit exists is rejected: the block still returns the data, but it clears nothing.

Top module: `thermal_log_word`

## Requirements
- R1: Word layout: bit 0 is thermal-control status and bit 1 its log, bit 2 is hot-signal status and bit 3 its log, bit 4 is critical-temperature status and bit 5 its log, and bits 31:6 read as zero.
- R2: Each condition input passes through a two-flop synchronizer. A change on an input sampled at clock edge k shows in the returned status bit for a read sampled at edge k+2, but not for a read sampled at edge k+1.
- R3: A log bit is set only by a 0-to-1 change of its synchronized status. It is visible to reads sampled from edge k+3 onward. A status that stays high does not set the log again once it has been cleared.
- R4: A log bit stays set after its status falls, and it changes only through a read-clear or reset.
- R5: During a read, a mask bit of 0 at position 1, 3 or 5 clears that log bit, and a mask bit of 1 leaves it unchanged. For example, mask 32'hFFFFFFFD clears only the thermal-control log.
- R6: A mask with a 0 at any position other than 1, 3 or 5 is illegal. The read then returns completion code 8'h90 and the current data, and it clears no log bit.
- R7: A read with a legal mask returns completion code 8'h40.
- R8: The returned data is the word before that read's clear takes effect.
- R9: If a rising edge of a status bit is due to set its log in the same cycle that a read clears that log, the log ends up set.
- R10: The valid output is high for exactly the one cycle after each request cycle, and low otherwise.
- R11: Reset clears all logs and all synchronizer and edge history. An input held high through reset is therefore logged as one rising edge after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tcc_active_i | input | 1 | Thermal control circuit active (asynchronous) |
| hot_sig_i | input | 1 | Bidirectional hot signal asserted (asynchronous) |
| crit_temp_i | input | 1 | Critical temperature reached (asynchronous) |
| rd_req_i | input | 1 | One-cycle read request |
| rd_mask_i | input | 32 | Active-low log clear mask, sampled with the request |
| rd_vld_o | output | 1 | Response valid, one cycle after the request |
| rd_data_o | output | 32 | Status word as it stood before the clear |
| rd_cc_o | output | 8 | Completion code: 8'h40 means success, 8'h90 means illegal mask |

## Verification
The hardest case to reach from the ports is a rising edge that lands on the exact clock edge where a read clears the same log bit. Through the synchronizer, that edge is two edges after the input changes. The bench counts the latency from the input drive and issues the clearing read one negedge later, so that the request is sampled on the very edge that sets the log. A second read then shows whether the set survived. The bench also sweeps every legal subset of clear bits over changing input patterns, and every single illegal zero position in the mask, each time with all logs set beforehand.

// File: rtl/thermal_log_word.sv
module thermal_log_word #(
  parameter int WORD_W = 32,
  parameter int SYNC_STAGES = 2,
  parameter logic [7:0] CC_OK = 8'h40,
  parameter logic [7:0] CC_BADMASK = 8'h90
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tcc_active_i,
  input  logic              hot_sig_i,
  input  logic              crit_temp_i,
  input  logic              rd_req_i,
  input  logic [WORD_W-1:0] rd_mask_i,
  output logic              rd_vld_o,
  output logic [WORD_W-1:0] rd_data_o,
  output logic [7:0]        rd_cc_o
);
  localparam int NCOND = 3;

  function automatic logic [WORD_W-1:0] log_positions();
    logic [WORD_W-1:0] m;
    m = '0;
    for (int i = 0; i < NCOND; i++) m[2*i+1] = 1'b1;
    return m;
  endfunction

  localparam logic [WORD_W-1:0] LOG_POS = log_positions();

  logic [NCOND-1:0] cond_raw;
  logic [NCOND-1:0] sync_q [SYNC_STAGES];
  logic [NCOND-1:0] cond, prev_q, rise, log_q, clr;
  logic [WORD_W-1:0] word;
  logic              illegal, do_clr;

  assign cond_raw = {crit_temp_i, hot_sig_i, tcc_active_i};
  assign cond     = sync_q[SYNC_STAGES-1];
  assign rise     = cond & ~prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SYNC_STAGES; s++) sync_q[s] <= '0;
    end else begin
      sync_q[0] <= cond_raw;
      for (int s = 1; s < SYNC_STAGES; s++) sync_q[s] <= sync_q[s-1];
    end
  end

  always_comb begin
    word = '0;
    for (int i = 0; i < NCOND; i++) begin
      word[2*i]   = cond[i];
      word[2*i+1] = log_q[i];
      clr[i]      = ~rd_mask_i[2*i+1];
    end
  end

  assign illegal = |(~rd_mask_i & ~LOG_POS);
  assign do_clr  = rd_req_i & ~illegal;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      log_q  <= '0;
    end else begin
      prev_q <= cond;
      log_q  <= (log_q & ~(do_clr ? clr : '0)) | rise;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld_o  <= 1'b0;
      rd_data_o <= '0;
      rd_cc_o   <= '0;
    end else begin
      rd_vld_o <= rd_req_i;
      if (rd_req_i) begin
        rd_data_o <= word;
        rd_cc_o   <= illegal ? CC_BADMASK : CC_OK;
      end
    end
  end

  p_vld_after_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_i |=> rd_vld_o);
  p_no_vld_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req_i |=> !rd_vld_o);
  p_cc_known_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld_o |-> (rd_cc_o == CC_OK || rd_cc_o == CC_BADMASK));
  p_reserved_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_vld_o |-> (rd_data_o & ~(LOG_POS | (LOG_POS >> 1))) == '0);
  p_log_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req_i |=> (log_q & $past(log_q)) == $past(log_q));
  p_bad_mask_keeps_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_i && illegal) |=> (log_q & $past(log_q)) == $past(log_q) && rd_cc_o == CC_BADMASK);
  p_rise_logged_r9: assert property (@(posedge clk) disable iff (!rst_n)
    |rise |=> (log_q & $past(rise)) == $past(rise));
endmodule

// File: tb/thermal_log_word_test.sv
module thermal_log_word_test;
  logic clk = 0, rst_n = 0;
  logic [2:0] cin = '0;
  logic rd_req = 0;
  logic [31:0] rd_mask = '1;
  logic rd_vld;
  logic [31:0] rd_data;
  logic [7:0] rd_cc;
  int checks = 0, fails = 0;
  logic [2:0] exp_log = '0;
  logic cap_vld;
  logic [31:0] cap_data;
  logic [7:0] cap_cc;

  always #4 clk = ~clk;

  thermal_log_word uut (
    .clk(clk), .rst_n(rst_n),
    .tcc_active_i(cin[0]), .hot_sig_i(cin[1]), .crit_temp_i(cin[2]),
    .rd_req_i(rd_req), .rd_mask_i(rd_mask),
    .rd_vld_o(rd_vld), .rd_data_o(rd_data), .rd_cc_o(rd_cc));

  function automatic logic [31:0] mkword(logic [2:0] st, logic [2:0] lg);
    logic [31:0] w = '0;
    for (int i = 0; i < 3; i++) begin w[2*i] = st[i]; w[2*i+1] = lg[i]; end
    return w;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_read(logic [31:0] m);
    rd_req = 1; rd_mask = m;
    @(negedge clk);
    rd_req = 0; rd_mask = '1;
    cap_vld = rd_vld; cap_data = rd_data; cap_cc = rd_cc;
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic apply(logic [2:0] v);
    exp_log |= v & ~cin;
    cin = v;
    wait_n(4);
  endtask

  task automatic model_read(string req, logic [31:0] m);
    logic legal;
    legal = ((~m) & ~32'h2A) == 0;
    do_read(m);
    chk(req, {31'b0, cap_vld}, 32'd1);
    chk(req, cap_data, mkword(cin, exp_log));
    chk(req, {24'b0, cap_cc}, legal ? 32'h40 : 32'h90);
    if (legal) exp_log &= ~{~m[5], ~m[3], ~m[1]};
  endtask

  task automatic do_reset();
    rst_n = 0; exp_log = '0;
    wait_n(2);
    rst_n = 1;
    @(negedge clk);
  endtask

  initial begin
    #1600000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    wait_n(3);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk("R11 reset vld", {31'b0, rd_vld}, 32'd0);
    do_read('1);
    chk("R11 reset data", cap_data, 32'h0);
    @(negedge clk);
    chk("R10 vld single cycle", {31'b0, rd_vld}, 32'd0);

    // R2/R3 latency
    cin = 3'b001;
    @(negedge clk);
    do_read('1);
    chk("R2 status not yet", cap_data, 32'h0);
    do_read('1);
    chk("R2 status after two", cap_data, 32'h1);
    do_read('1);
    chk("R3 log after three", cap_data, 32'h3);
    exp_log = 3'b001;
    // R3 level does not re-set
    model_read("R5 clear tcc", 32'hFFFFFFFD);
    wait_n(3);
    model_read("R3 no relog on level", '1);
    // R4 log survives falling status
    apply(3'b000); apply(3'b010);
    apply(3'b000);
    model_read("R4 log held after fall", '1);
    model_read("R5 clear hot only", 32'hFFFFFFF7);

    // R9 set wins
    cin = 3'b100;
    @(negedge clk); @(negedge clk);
    do_read(32'hFFFFFFDF);
    chk("R8 pre-clear data", cap_data, 32'h10);
    chk("R7 cc", {24'b0, cap_cc}, 32'h40);
    exp_log = 3'b100;
    wait_n(2);
    model_read("R9 set wins over clear", '1);

    // R5/R7/R8 sweep: legal masks
    for (int s = 0; s < 64; s++) begin
      logic [2:0] v, sel;
      v = s[2:0] ^ s[5:3];
      sel = s[2:0] + s[5:3];
      apply(v);
      model_read("R5 legal sweep", ~{26'b0, sel[2], 1'b0, sel[1], 1'b0, sel[0], 1'b0});
      model_read("R8 post-clear", '1);
    end

    // R6 illegal single zero positions
    for (int p = 0; p < 32; p++) begin
      if (p == 1 || p == 3 || p == 5) continue;
      apply(3'b000); apply(3'b111);
      model_read("R6 illegal mask", ~(32'h1 << p) & ~32'h2A);
      model_read("R6 logs kept", '1);
    end

    // R11 input high through reset
    cin = 3'b010;
    do_reset();
    cin = 3'b010;
    exp_log = 3'b010;
    wait_n(4);
    model_read("R11 high through reset logged", '1);
    @(negedge clk);
    chk("R10 vld idle", {31'b0, rd_vld}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule